// File: doc/BRIEF.md
# FM Operator Algorithm Router

This block produces one sample of a four-operator FM voice by calling a single shared operator unit four times and combining the results. A one-cycle pulse on `start` begins a sample. The block then latches the 3-bit algorithm select, issues four operator requests in index order (0, 1, 2, 3) and forms the modulation input of each request from the outputs already returned. When the last response arrives, it sums the carrier outputs that the algorithm names and presents the result on `sample_out` with a one-cycle `sample_valid` strobe.

The operator unit itself is outside the block. It may answer a request in the same cycle or after any number of wait cycles. Each request stays asserted, with a steady index and modulation value, until the matching response is taken. Internal sums carry two guard bits above the operator width. Combined branches are added without any division. The final sum is clamped to the output width rather than wrapped.

Top module: `fm_alg_router`

## Requirements
- R1: After a synchronous reset, `op_req` and `sample_valid` are 0 and `sample_out` is 0.
- R2: A `start` pulse in the idle state leads, on the next cycle, to `op_req`=1 with `op_idx`=0 and `op_mod`=0. The four operators are requested one at a time in index order 0,1,2,3. Each request holds its index and modulation steady until a cycle with `op_rsp_valid`=1 takes the response.
- R3: Algorithm 0 (`alg`=3'd0) is a serial chain: operator n+1 is modulated by operator n's output, and operator 3's output is the sample.
- R4: Algorithm 1: operators 0 and 1 are unmodulated. Their sum modulates operator 2, operator 2 modulates operator 3, and operator 3 is the sample.
- R5: Algorithm 2: operators 0 and 1 are unmodulated, and operator 1 modulates operator 2. The sum of operators 0 and 2 modulates operator 3, which is the sample.
- R6: Algorithm 3: operator 0 modulates operator 1, and operator 2 is unmodulated. The sum of operators 1 and 2 modulates operator 3, which is the sample.
- R7: Algorithm 4: two chains, 0→1 and 2→3, with operators 0 and 2 unmodulated. The sample is operator 1 plus operator 3.
- R8: Algorithm 5: operator 0 is unmodulated and modulates each of operators 1, 2 and 3. The sample is the sum of operators 1, 2 and 3.
- R9: Algorithm 6: operator 0 modulates operator 1, and operators 2 and 3 are unmodulated. The sample is the sum of operators 1, 2 and 3.
- R10: Algorithm 7: all four operators are unmodulated, and the sample is the sum of all four.
- R11: Sums are never divided by the number of terms. A sum above the largest value of the OUT_W-bit signed range gives that maximum (8191 for 14 bits). A sum below the range gives its minimum (-8192).
- R12: `alg` is sampled only when a sample starts. A change to `alg` while a sample is in progress affects only the next sample.
- R13: `sample_valid` is high for exactly the one cycle after the cycle in which operator 3's response is taken, and the block is idle (`op_req`=0) in that cycle. A `start` pulse while a sample is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one sample computation (honoured when idle) |
| alg | input | 3 | Algorithm select, latched at start |
| op_req | output | 1 | Operator request pending |
| op_idx | output | 2 | Index of the requested operator |
| op_mod | output | OP_W+2 | Signed modulation input of the request |
| op_rsp_valid | input | 1 | Operator response valid; completes the pending request |
| op_rsp_data | input | OP_W | Signed operator output |
| sample_valid | output | 1 | One-cycle strobe: channel sample ready |
| sample_out | output | OUT_W | Signed, saturated channel sample |

## Verification
The hardest case to reach is a modulation or output value that depends on results returned several requests earlier, under varied response latency. An error there stays hidden unless each operator returns a distinct value that also depends on its modulation input. The bench's responder therefore returns a per-operator amplitude plus a quarter of the modulation it received. It answers after 0, 1 or 2 wait cycles, so every routing path changes both later requests and the final sum. Saturation comes from driving all four amplitudes near full scale in the all-carrier algorithm. The sample-time latch is tested by changing `alg`, and by pulsing `start` again, partway through a sample.

// File: rtl/fm_route_pkg.sv
package fm_route_pkg;

    localparam int NUM_OPS = 4;
    localparam int GUARD   = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } route_state_e;

    // Bit i set: the stored output of operator i joins the modulation sum
    // for the operator requested at this step.
    function automatic logic [NUM_OPS-1:0] mod_taps(input logic [2:0] alg,
                                                    input logic [1:0] step);
        logic [NUM_OPS-1:0] t;
        t = '0;
        case (step)
            2'd1: begin
                if (alg inside {3'd0, 3'd3, 3'd4, 3'd5, 3'd6}) t = 4'b0001;
            end
            2'd2: begin
                case (alg)
                    3'd0, 3'd2: t = 4'b0010;
                    3'd1:       t = 4'b0011;
                    3'd5:       t = 4'b0001;
                    default:    t = 4'b0000;
                endcase
            end
            2'd3: begin
                case (alg)
                    3'd0, 3'd1, 3'd4: t = 4'b0100;
                    3'd2:             t = 4'b0101;
                    3'd3:             t = 4'b0110;
                    3'd5:             t = 4'b0001;
                    default:          t = 4'b0000;
                endcase
            end
            default: t = 4'b0000;
        endcase
        return t;
    endfunction

    // Bit i set: operator i is a carrier summed into the channel sample.
    function automatic logic [NUM_OPS-1:0] out_taps(input logic [2:0] alg);
        logic [NUM_OPS-1:0] t;
        case (alg)
            3'd4:       t = 4'b1010;
            3'd5, 3'd6: t = 4'b1110;
            3'd7:       t = 4'b1111;
            default:    t = 4'b1000;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fm_term_sum.sv
module fm_term_sum
    import fm_route_pkg::*;
#(
    parameter int IN_W  = 14,
    parameter int SUM_W = 16
) (
    input  logic [NUM_OPS-1:0]          taps,
    input  logic signed [IN_W-1:0]      terms [NUM_OPS],
    output logic signed [SUM_W-1:0]     sum
);

    logic signed [SUM_W-1:0] gated [NUM_OPS];

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_gate
        assign gated[g] = taps[g] ? SUM_W'(terms[g]) : '0;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            sum = sum + gated[i];
        end
    end

endmodule

// File: rtl/fm_sat.sv
module fm_sat #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 14
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);

    if (OUT_W >= IN_W) begin : g_wide
        always_comb dout = OUT_W'(din);
    end else begin : g_clamp
        localparam logic signed [IN_W-1:0] MAX_V = IN_W'((2 ** (OUT_W - 1)) - 1);
        localparam logic signed [IN_W-1:0] MIN_V = IN_W'(-(2 ** (OUT_W - 1)));
        always_comb begin
            if (din > MAX_V)      dout = MAX_V[OUT_W-1:0];
            else if (din < MIN_V) dout = MIN_V[OUT_W-1:0];
            else                  dout = din[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/fm_alg_router.sv
module fm_alg_router
    import fm_route_pkg::*;
#(
    parameter int OP_W  = 14,
    parameter int OUT_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [2:0]               alg,
    output logic                     op_req,
    output logic [1:0]               op_idx,
    output logic [OP_W+GUARD-1:0]    op_mod,
    input  logic                     op_rsp_valid,
    input  logic [OP_W-1:0]          op_rsp_data,
    output logic                     sample_valid,
    output logic [OUT_W-1:0]         sample_out
);

    localparam int ACC_W = OP_W + GUARD;
    localparam logic [1:0] LAST_STEP = 2'(NUM_OPS - 1);

    route_state_e            state_q;
    logic [1:0]              step_q;
    logic [2:0]              alg_q;
    logic signed [OP_W-1:0]  res_q [NUM_OPS];

    logic signed [OP_W-1:0]  mod_terms [NUM_OPS];
    logic signed [OP_W-1:0]  out_terms [NUM_OPS];
    logic signed [ACC_W-1:0] mod_sum;
    logic signed [ACC_W-1:0] out_sum;
    logic signed [OUT_W-1:0] out_sat;
    logic                    take_rsp;

    always_comb begin
        for (int i = 0; i < NUM_OPS - 1; i++) begin
            mod_terms[i] = res_q[i];
            out_terms[i] = res_q[i];
        end
        mod_terms[NUM_OPS-1] = '0;
        out_terms[NUM_OPS-1] = $signed(op_rsp_data);
    end

    fm_term_sum #(.IN_W(OP_W), .SUM_W(ACC_W)) u_mod_sum (
        .taps  (mod_taps(alg_q, step_q)),
        .terms (mod_terms),
        .sum   (mod_sum)
    );

    fm_term_sum #(.IN_W(OP_W), .SUM_W(ACC_W)) u_out_sum (
        .taps  (out_taps(alg_q)),
        .terms (out_terms),
        .sum   (out_sum)
    );

    fm_sat #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_sat (
        .din  (out_sum),
        .dout (out_sat)
    );

    assign op_req   = (state_q == ST_RUN);
    assign op_idx   = step_q;
    assign op_mod   = mod_sum;
    assign take_rsp = op_req && op_rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            step_q       <= '0;
            alg_q        <= '0;
            sample_valid <= 1'b0;
            sample_out   <= '0;
            for (int i = 0; i < NUM_OPS; i++) res_q[i] <= '0;
        end else begin
            sample_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        alg_q   <= alg;
                        step_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (op_rsp_valid) begin
                        res_q[step_q] <= $signed(op_rsp_data);
                        if (step_q == LAST_STEP) begin
                            sample_out   <= out_sat;
                            sample_valid <= 1'b1;
                            state_q      <= ST_IDLE;
                        end else begin
                            step_q <= step_q + 2'd1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_req && !op_rsp_valid) |=> (op_req && $stable(op_idx) && $stable(op_mod)));

    // R2
    req_order_chk: assert property (@(posedge clk) disable iff (rst)
        (take_rsp && op_idx != LAST_STEP) |=> (op_req && op_idx == $past(op_idx) + 2'd1));

    // R2
    first_unmod_chk: assert property (@(posedge clk) disable iff (rst)
        (op_req && op_idx == 2'd0) |-> (op_mod == '0));

    // R13
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R13
    valid_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ($past(take_rsp && op_idx == LAST_STEP) && !op_req));

endmodule

// File: tb/sim_fm_alg_router.sv
`timescale 1ns/1ps
module sim_fm_alg_router;

    localparam int OP_W  = 14;
    localparam int OUT_W = 14;
    localparam int ACC_W = OP_W + 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [2:0]         alg = 3'd0;
    logic               op_req;
    logic [1:0]         op_idx;
    logic [ACC_W-1:0]   op_mod;
    logic               op_rsp_valid = 1'b0;
    logic [OP_W-1:0]    op_rsp_data = '0;
    logic               sample_valid;
    logic [OUT_W-1:0]   sample_out;

    always #10 clk = ~clk;

    fm_alg_router #(.OP_W(OP_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .alg(alg),
        .op_req(op_req), .op_idx(op_idx), .op_mod(op_mod),
        .op_rsp_valid(op_rsp_valid), .op_rsp_data(op_rsp_data),
        .sample_valid(sample_valid), .sample_out(sample_out)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int  m_alg = 0;
    int  m_lat = 0;
    int  m_step = 0;
    int  m_wait = 0;
    int  amp [4];
    int  r [4];
    int  exp_out = 0;
    bit  exp_valid_next = 0;
    bit  m_done = 0;
    bit  finished = 0;

    function automatic string alg_tag(int a);
        case (a)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int clip(int v, int bits);
        int hi, lo;
        hi = (1 << (bits - 1)) - 1;
        lo = -(1 << (bits - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int want_mod(int a, int idx);
        case (a)
            0: return (idx == 0) ? 0 : r[idx-1];
            1: return (idx == 2) ? r[0] + r[1] : (idx == 3) ? r[2] : 0;
            2: return (idx == 2) ? r[1] : (idx == 3) ? r[0] + r[2] : 0;
            3: return (idx == 1) ? r[0] : (idx == 3) ? r[1] + r[2] : 0;
            4: return (idx == 1) ? r[0] : (idx == 3) ? r[2] : 0;
            5: return (idx == 0) ? 0 : r[0];
            6: return (idx == 1) ? r[0] : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int want_out(int a);
        case (a)
            4:       return r[1] + r[3];
            5, 6:    return r[1] + r[2] + r[3];
            7:       return r[0] + r[1] + r[2] + r[3];
            default: return r[3];
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
        end
    endtask

    // Per-cycle reference model and operator responder
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (exp_valid_next) begin
                check(sample_valid == 1'b1, "R13", "strobe after last response", int'(sample_valid), 1);
                check($signed(sample_out) == exp_out, alg_tag(m_alg), "sample value",
                      int'($signed(sample_out)), exp_out);
                check(op_req == 1'b0, "R13", "idle with strobe", int'(op_req), 0);
                exp_valid_next = 0;
                m_done = 1;
            end else begin
                check(sample_valid == 1'b0, "R13", "no stray strobe", int'(sample_valid), 0);
            end
            op_rsp_valid = 1'b0;
            if (op_req) begin
                if (m_wait >= m_lat) begin
                    int mv, d;
                    mv = want_mod(m_alg, m_step);
                    check(int'(op_idx) == m_step, "R2", "operator order", int'(op_idx), m_step);
                    check($signed(op_mod) == mv, alg_tag(m_alg), "modulation input",
                          int'($signed(op_mod)), mv);
                    d = clip(amp[m_step] + int'($signed(op_mod)) / 4, OP_W);
                    r[m_step] = d;
                    op_rsp_data = OP_W'(d);
                    op_rsp_valid = 1'b1;
                    m_wait = 0;
                    m_step++;
                    if (m_step == 4) begin
                        exp_out = clip(want_out(m_alg), OUT_W);
                        exp_valid_next = 1;
                        m_step = 0;
                    end
                end else begin
                    m_wait++;
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic run_sample(input int a, input int lat,
                              input int a0, input int a1, input int a2, input int a3,
                              input bit poke_start, input bit swap_alg);
        int guard;
        m_lat = lat;
        amp[0] = a0; amp[1] = a1; amp[2] = a2; amp[3] = a3;
        m_done = 0;
        @(negedge clk);
        alg = 3'(a);
        m_alg = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        if (swap_alg) alg = 3'(a ^ 7);
        if (poke_start) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!m_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (!m_done) begin
            errors++;
            $display("FAIL R13 sample completion: got 0 expected 1");
        end
        @(negedge clk);
        // R13: any ignored start must not have launched another sample
        check(op_req == 1'b0, "R13", "idle after sample", int'(op_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(op_req == 1'b0, "R1", "op_req in reset", int'(op_req), 0);
        check(sample_valid == 1'b0, "R1", "sample_valid in reset", int'(sample_valid), 0);
        check(sample_out == '0, "R1", "sample_out in reset", int'(sample_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(op_req == 1'b0, "R1", "idle after reset", int'(op_req), 0);

        // R3..R10: each algorithm, varied latency and amplitudes
        for (int a = 0; a < 8; a++) begin
            run_sample(a, a % 3, 400 + 37 * a, -300 + 11 * a, 250, -120 + a, 0, 0);
            run_sample(a, (a + 1) % 3, 1200, 800, -900, 640, 0, 0);
        end

        // R11: no averaging, then clamping at both ends
        run_sample(7, 0, 100, 200, 300, 400, 0, 0);
        run_sample(7, 1, 8000, 8000, 8000, 8000, 0, 0);
        run_sample(7, 2, -8000, -8000, -8000, -8000, 0, 0);
        run_sample(5, 0, 8000, 6000, 6000, 6000, 0, 0);

        // R12: alg change mid-sample applies only to the next one
        run_sample(4, 2, 500, -700, 900, 300, 0, 1);
        run_sample(3, 1, 500, -700, 900, 300, 0, 1);

        // R13: start pulse during a sample is ignored
        run_sample(1, 2, 333, 444, -555, 666, 1, 0);
        run_sample(6, 1, -1000, 2000, 3000, -4000, 1, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule